// File: doc/BRIEF.md
# Spike Packet Router with Default and Adaptive Routing

This block sits behind an input arbiter and decides, for one packet at a time, which output ports it leaves on. A packet comes in with the index of the link it arrived on. The router first checks the packet's parity. It then reads a two-bit class field and hands the packet to one of three engines.

Multicast packets are looked up by the source key they carry, in a small table of key/mask entries. Software can rewrite the table while traffic flows. On a miss, a multicast packet leaves on the link opposite the one it came in on. Point-to-point packets select one link, or the local processor port, from their key. Nearest-neighbour packets are sent to the system-bus side and not to any link.

Before a packet is emitted, each external link it asks for must be ready and free of faults. A link marked faulty is replaced at once by its clockwise neighbour. A link that is only busy is replaced after a programmable wait. If the replacement link cannot be used either, the packet is dropped and a drop counter is incremented.

Top module: `adaptive_router`

## Requirements
- R1: A packet whose bits have odd parity (the XOR of all bits, including the top parity bit, is 1) produces no output and does not change the drop counter.
- R2: The class is taken from packet bits [1:0]: 0 is multicast, 1 is point-to-point, 2 is nearest-neighbour. Class 3 is discarded without output.
- R3: A multicast packet hits table entry i when entry i is enabled and (key AND mask_i) equals key_i, where the key is packet bits [33:2]. The output bitmap is that entry's port bitmap: bits 0..5 are links and bits 6..7 are local ports. When several entries hit, the lowest index wins.
- R4: A multicast miss leaves on link (in_link+3) mod 6. A miss from a local source (in_link ≥ 6) is discarded.
- R5: A point-to-point packet goes to link k when key[2:0] = k < 6. Values 6 and 7 go to local port bit 6.
- R6: A nearest-neighbour packet is emitted with out_bus=1 and out_ports=0.
- R7: A packet is accepted on an edge where in_valid and in_ready are both high. in_ready is low for the next cycle. When every requested link can be used, out_valid pulses high for one cycle after the following edge.
- R8: A requested link that is not ready, and not faulty, holds the packet for wait_limit evaluation edges. On the next edge it is replaced by link (i+1) mod 6.
- R9: A requested link with link_fault set is replaced by its clockwise neighbour on the first evaluation edge. No emitted external port bit is ever a link that was unusable on the emitting edge.
- R10: If a replacement link is itself unusable, the packet is discarded and drop_count increases by exactly one.
- R11: A table write (tbl_we) loads entry tbl_idx. Lookups after the write edge use the new contents.
- R12: Local port bits never block. A packet routed only to local ports is emitted even when no link is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Router can accept a packet |
| in_pkt | input | PKT_W | Packet: [1:0] class, [33:2] key, top bit parity |
| in_link | input | 3 | Arrival link, 6 or more means local |
| link_ready | input | NL | Per-link ready |
| link_fault | input | NL | Per-link fault mark |
| wait_limit | input | WAIT_W | Edges to wait on a busy link before rerouting |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_en | input | 1 | Enable bit written to the entry |
| tbl_key | input | KEY_W | Entry key |
| tbl_mask | input | KEY_W | Entry mask |
| tbl_ports | input | NL+NP | Entry port bitmap |
| out_valid | output | 1 | Routed packet present |
| out_pkt | output | PKT_W | Routed packet |
| out_ports | output | NL+NP | Output port bitmap |
| out_bus | output | 1 | Packet goes to the system-bus side |
| drop_count | output | CNT_W | Packets dropped for lack of a link |

## Verification
The packet is accepted on an edge E. A packet whose links are usable, a nearest-neighbour packet, a discarded packet and a fault reroute all settle on E+1. The bench therefore samples out_valid, out_ports, out_bus and drop_count at the falling edge after E+1, and it checks in_ready at the falling edge after E. With a busy link and wait limit W, the reroute lands on edge E+1+W. The bench checks that out_valid stays low at each falling edge before that edge and is high at the falling edge just after it.

// File: rtl/router_pkg.sv
package router_pkg;
  typedef enum logic [1:0] {
    CLS_MCAST = 2'd0,
    CLS_P2P   = 2'd1,
    CLS_NBR   = 2'd2,
    CLS_RSVD  = 2'd3
  } pkt_class_e;

  localparam int CLS_LSB = 0;
  localparam int KEY_LSB = 2;
endpackage

// File: rtl/router_key_table.sv
module router_key_table #(
  parameter int N_ENT  = 8,
  parameter int KEY_W  = 32,
  parameter int PORT_W = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic              wen,
  input  logic [KEY_W-1:0]  wkey,
  input  logic [KEY_W-1:0]  wmask,
  input  logic [PORT_W-1:0] wports,
  input  logic [KEY_W-1:0]  lkey,
  output logic              hit,
  output logic [PORT_W-1:0] hports
);
  logic [N_ENT-1:0]  ent_on;
  logic [KEY_W-1:0]  ent_key   [N_ENT];
  logic [KEY_W-1:0]  ent_mask  [N_ENT];
  logic [PORT_W-1:0] ent_ports [N_ENT];

  always_ff @(posedge clk) begin
    if (rst) ent_on <= '0;
    else if (we) ent_on[widx] <= wen;
  end

  // Entry contents carry no reset, so storage maps onto plain RAM bits.
  always_ff @(posedge clk) begin
    if (we) begin
      ent_key[widx]   <= wkey;
      ent_mask[widx]  <= wmask;
      ent_ports[widx] <= wports;
    end
  end

  // Scan from the top down so that the lowest matching index is kept.
  always_comb begin
    hit    = 1'b0;
    hports = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (ent_on[i] && ((lkey & ent_mask[i]) == ent_key[i])) begin
        hit    = 1'b1;
        hports = ent_ports[i];
      end
    end
  end
endmodule

// File: rtl/router_link_select.sv
module router_link_select #(
  parameter int NL = 6,
  parameter int NP = 2,
  localparam int PORT_W = NL + NP
) (
  input  logic [PORT_W-1:0] req,
  input  logic [NL-1:0]     link_ready,
  input  logic [NL-1:0]     link_fault,
  input  logic              expired,
  output logic              go,
  output logic              drop,
  output logic [PORT_W-1:0] ports
);
  logic [NL-1:0] usable, blocked, moved;

  assign usable  = link_ready & ~link_fault;
  assign blocked = req[NL-1:0] & ~usable;

  for (genvar i = 0; i < NL; i++) begin : g_cw
    assign moved[(i + 1) % NL] = blocked[i];
  end

  always_comb begin
    go    = 1'b0;
    drop  = 1'b0;
    ports = req;
    if (blocked == '0) begin
      go = 1'b1;
    end else if (((req[NL-1:0] & link_fault) != '0) || expired) begin
      if ((moved & ~usable) == '0) begin
        go    = 1'b1;
        ports = {req[PORT_W-1:NL], (req[NL-1:0] & usable) | moved};
      end else begin
        drop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adaptive_router.sv
module adaptive_router #(
  parameter int NL     = 6,
  parameter int NP     = 2,
  parameter int KEY_W  = 32,
  parameter int PKT_W  = 40,
  parameter int N_ENT  = 8,
  parameter int WAIT_W = 8,
  parameter int CNT_W  = 8,
  localparam int PORT_W = NL + NP,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int LNK_W  = $clog2(NL + 1),
  localparam int HALF   = NL / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  in_pkt,
  input  logic [LNK_W-1:0]  in_link,
  input  logic [NL-1:0]     link_ready,
  input  logic [NL-1:0]     link_fault,
  input  logic [WAIT_W-1:0] wait_limit,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic              tbl_en,
  input  logic [KEY_W-1:0]  tbl_key,
  input  logic [KEY_W-1:0]  tbl_mask,
  input  logic [PORT_W-1:0] tbl_ports,
  output logic              out_valid,
  output logic [PKT_W-1:0]  out_pkt,
  output logic [PORT_W-1:0] out_ports,
  output logic              out_bus,
  output logic [CNT_W-1:0]  drop_count
);
  import router_pkg::*;

  logic              busy_q;
  logic [PKT_W-1:0]  hold_pkt;
  logic [LNK_W-1:0]  hold_link;
  logic [WAIT_W-1:0] wcnt;

  pkt_class_e        cls;
  logic [KEY_W-1:0]  key;
  logic              par_ok, tbl_hit, routable, to_bus;
  logic [PORT_W-1:0] tbl_hports, req;
  logic [LNK_W-1:0]  opp, dst;
  logic              sel_go, sel_drop;
  logic [PORT_W-1:0] sel_ports;

  assign in_ready = ~busy_q;
  assign cls      = pkt_class_e'(hold_pkt[CLS_LSB +: 2]);
  assign key      = hold_pkt[KEY_LSB +: KEY_W];
  assign par_ok   = ~(^hold_pkt);
  assign dst      = key[LNK_W-1:0];
  assign opp      = (hold_link >= LNK_W'(HALF)) ? hold_link - LNK_W'(HALF)
                                                : hold_link + LNK_W'(HALF);

  router_key_table #(
    .N_ENT(N_ENT), .KEY_W(KEY_W), .PORT_W(PORT_W)
  ) u_table (
    .clk(clk), .rst(rst), .we(tbl_we), .widx(tbl_idx), .wen(tbl_en),
    .wkey(tbl_key), .wmask(tbl_mask), .wports(tbl_ports),
    .lkey(key), .hit(tbl_hit), .hports(tbl_hports)
  );

  // One engine per class; a parity failure disables all of them.
  always_comb begin
    req      = '0;
    routable = 1'b0;
    to_bus   = 1'b0;
    unique case (cls)
      CLS_MCAST: begin
        if (tbl_hit) begin
          req      = tbl_hports;
          routable = 1'b1;
        end else if (hold_link < LNK_W'(NL)) begin
          req[opp] = 1'b1;
          routable = 1'b1;
        end
      end
      CLS_P2P: begin
        if (dst < LNK_W'(NL)) req[dst] = 1'b1;
        else                  req[NL]  = 1'b1;
        routable = 1'b1;
      end
      CLS_NBR: begin
        to_bus   = 1'b1;
        routable = 1'b1;
      end
      default: routable = 1'b0;
    endcase
    if (!par_ok) routable = 1'b0;
  end

  router_link_select #(.NL(NL), .NP(NP)) u_select (
    .req(req), .link_ready(link_ready), .link_fault(link_fault),
    .expired(wcnt >= wait_limit),
    .go(sel_go), .drop(sel_drop), .ports(sel_ports)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      hold_pkt   <= '0;
      hold_link  <= '0;
      wcnt       <= '0;
      out_valid  <= 1'b0;
      out_pkt    <= '0;
      out_ports  <= '0;
      out_bus    <= 1'b0;
      drop_count <= '0;
    end else begin
      out_valid <= 1'b0;
      out_bus   <= 1'b0;
      if (!busy_q) begin
        if (in_valid) begin
          busy_q    <= 1'b1;
          hold_pkt  <= in_pkt;
          hold_link <= in_link;
          wcnt      <= '0;
        end
      end else if (!routable) begin
        busy_q <= 1'b0;
      end else if (to_bus) begin
        busy_q    <= 1'b0;
        out_valid <= 1'b1;
        out_bus   <= 1'b1;
        out_ports <= '0;
        out_pkt   <= hold_pkt;
      end else if (sel_go) begin
        busy_q    <= 1'b0;
        out_valid <= 1'b1;
        out_ports <= sel_ports;
        out_pkt   <= hold_pkt;
      end else if (sel_drop) begin
        busy_q     <= 1'b0;
        drop_count <= drop_count + 1'b1;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/router_checker.sv
module router_checker #(
  parameter int NL    = 6,
  parameter int NP    = 2,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [NL-1:0]    link_ready,
  input logic [NL-1:0]    link_fault,
  input logic             out_valid,
  input logic [NL+NP-1:0] out_ports,
  input logic             out_bus,
  input logic [CNT_W-1:0] drop_count
);
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_emit_needs_work_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(!in_ready));

  p_bus_no_links_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bus) |-> (out_ports == '0));

  p_emit_usable_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_ports[NL-1:0] & ~$past(link_ready & ~link_fault)) == '0));

  p_drop_step_r10: assert property (@(posedge clk) disable iff (rst)
    (drop_count == $past(drop_count)) ||
    (drop_count == CNT_W'($past(drop_count) + 1'b1)));
endmodule

bind adaptive_router router_checker #(.NL(NL), .NP(NP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .link_ready(link_ready), .link_fault(link_fault), .out_valid(out_valid),
  .out_ports(out_ports), .out_bus(out_bus), .drop_count(drop_count)
);

// File: tb/adaptive_router_bench.sv
`timescale 1ns/1ps
module adaptive_router_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [39:0] in_pkt;
  logic [2:0]  in_link;
  logic [5:0]  link_ready, link_fault;
  logic [7:0]  wait_limit;
  logic        tbl_we, tbl_en;
  logic [2:0]  tbl_idx;
  logic [31:0] tbl_key, tbl_mask;
  logic [7:0]  tbl_ports;
  logic        out_valid, out_bus;
  logic [39:0] out_pkt;
  logic [7:0]  out_ports;
  logic [7:0]  drop_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  adaptive_router u_adaptive_router (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pkt(in_pkt), .in_link(in_link), .link_ready(link_ready),
    .link_fault(link_fault), .wait_limit(wait_limit), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_en(tbl_en), .tbl_key(tbl_key),
    .tbl_mask(tbl_mask), .tbl_ports(tbl_ports), .out_valid(out_valid),
    .out_pkt(out_pkt), .out_ports(out_ports), .out_bus(out_bus),
    .drop_count(drop_count)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  cls;
    logic [31:0] key;
    logic [2:0]  link;
    logic        bad;
    logic        ev;
    logic        eb;
    logic [7:0]  ep;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  2'd0, 32'h0000_1234, 3'd1, 1'b0, 1'b1, 1'b0, 8'h41}, // R3 both hit, entry 0 wins
    '{4'd3,  2'd0, 32'h0000_1534, 3'd4, 1'b0, 1'b1, 1'b0, 8'h84}, // R3 entry 1 only
    '{4'd4,  2'd0, 32'h0000_2000, 3'd1, 1'b0, 1'b1, 1'b0, 8'h10}, // R4 miss, 1 -> 4
    '{4'd4,  2'd0, 32'h0000_2000, 3'd5, 1'b0, 1'b1, 1'b0, 8'h04}, // R4 miss, 5 -> 2
    '{4'd4,  2'd0, 32'h0000_2000, 3'd6, 1'b0, 1'b0, 1'b0, 8'h00}, // R4 local miss discarded
    '{4'd5,  2'd1, 32'h0000_0003, 3'd0, 1'b0, 1'b1, 1'b0, 8'h08}, // R5 link 3
    '{4'd5,  2'd1, 32'h0000_0007, 3'd2, 1'b0, 1'b1, 1'b0, 8'h40}, // R5 local
    '{4'd5,  2'd1, 32'h0000_0000, 3'd3, 1'b0, 1'b1, 1'b0, 8'h01}, // R5 link 0
    '{4'd6,  2'd2, 32'h0000_0055, 3'd2, 1'b0, 1'b1, 1'b1, 8'h00}, // R6 bus side
    '{4'd2,  2'd3, 32'h0000_1234, 3'd1, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 reserved class
    '{4'd1,  2'd0, 32'h0000_1234, 3'd1, 1'b1, 1'b0, 1'b0, 8'h00}  // R1 odd parity
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic twrite(input logic [2:0] idx, input logic en, input logic [31:0] k,
                        input logic [31:0] m, input logic [7:0] p);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_en = en; tbl_key = k; tbl_mask = m; tbl_ports = p;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Returns at the falling edge after the accepting edge.
  task automatic send(input logic [1:0] cls, input logic [31:0] key,
                      input logic [2:0] link, input logic bad);
    logic [39:0] p;
    p = {1'b0, 5'h0a, key, cls};
    p[39] = (^p[38:0]) ^ bad;
    @(negedge clk);
    in_pkt = p; in_link = link; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 ready low after accept", {31'd0, in_ready}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d0;
    rst = 1'b1; in_valid = 1'b0; in_pkt = '0; in_link = '0;
    link_ready = 6'h3f; link_fault = '0; wait_limit = 8'd5;
    tbl_we = 1'b0; tbl_idx = '0; tbl_en = 1'b0; tbl_key = '0; tbl_mask = '0; tbl_ports = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R7 reset in_ready", {31'd0, in_ready}, 32'd1);
    chk("R7 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10 reset drop_count", {24'd0, drop_count}, 32'd0);

    twrite(3'd0, 1'b1, 32'h0000_1200, 32'hFFFF_FF00, 8'h41);
    twrite(3'd1, 1'b1, 32'h0000_1000, 32'hFFFF_F000, 8'h84);

    for (int i = 0; i < NV; i++) begin
      d0 = drop_count;
      send(VEC[i].cls, VEC[i].key, VEC[i].link, VEC[i].bad);
      @(negedge clk);
      chk($sformatf("R%0d vec %0d valid", VEC[i].rq, i), {31'd0, out_valid}, {31'd0, VEC[i].ev});
      if (VEC[i].ev) begin
        chk($sformatf("R%0d vec %0d ports", VEC[i].rq, i), {24'd0, out_ports}, {24'd0, VEC[i].ep});
        chk($sformatf("R%0d vec %0d bus", VEC[i].rq, i), {31'd0, out_bus}, {31'd0, VEC[i].eb});
      end else begin
        chk($sformatf("R%0d vec %0d drops", VEC[i].rq, i), {24'd0, drop_count}, {24'd0, d0});
      end
    end

    // R8: busy link 2, limit 3 -> stays silent 3 edges, then link 3.
    wait_limit = 8'd3; link_ready = 6'h3b;
    send(2'd1, 32'd2, 3'd0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 waiting", {31'd0, out_valid}, 32'd0);
    end
    @(negedge clk);
    chk("R8 reroute valid", {31'd0, out_valid}, 32'd1);
    chk("R8 reroute ports", {24'd0, out_ports}, 32'h08);

    // R9: faulty link 0 replaced at once by link 1.
    link_ready = 6'h3f; link_fault = 6'h01;
    send(2'd1, 32'd0, 3'd3, 1'b0);
    @(negedge clk);
    chk("R9 fault valid", {31'd0, out_valid}, 32'd1);
    chk("R9 fault ports", {24'd0, out_ports}, 32'h02);

    // R9 with R3: multicast entry 0 (link0+local0), link 0 faulty.
    send(2'd0, 32'h0000_1234, 3'd2, 1'b0);
    @(negedge clk);
    chk("R9 mcast reroute ports", {24'd0, out_ports}, 32'h42);

    // R10: link 4 faulty, neighbour 5 busy -> drop.
    link_fault = 6'h10; link_ready = 6'h1f; d0 = drop_count;
    send(2'd1, 32'd4, 3'd0, 1'b0);
    @(negedge clk);
    chk("R10 no output", {31'd0, out_valid}, 32'd0);
    chk("R10 drop count", {24'd0, drop_count}, {24'd0, d0 + 8'd1});

    // R11: rewrite entry 0 so key 0x2000 hits with link 5.
    link_fault = '0; link_ready = 6'h3f;
    twrite(3'd0, 1'b1, 32'h0000_2000, 32'hFFFF_FFFF, 8'h20);
    send(2'd0, 32'h0000_2000, 3'd1, 1'b0);
    @(negedge clk);
    chk("R11 new entry ports", {24'd0, out_ports}, 32'h20);

    // R12: local-only route with every link busy.
    twrite(3'd2, 1'b1, 32'h0000_3000, 32'hFFFF_FFFF, 8'h80);
    link_ready = '0; wait_limit = 8'd50;
    send(2'd0, 32'h0000_3000, 3'd1, 1'b0);
    @(negedge clk);
    chk("R12 local valid", {31'd0, out_valid}, 32'd1);
    chk("R12 local ports", {24'd0, out_ports}, 32'h80);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule